// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block exposes a calendar clock as the eight highest byte locations of an 8K x 8 address space. Every other address belongs to an ordinary RAM outside the block: for those addresses the block only steers the select to that RAM and passes its read data back. Inside the block, a set of live counters counts seconds, minutes, hours, day of week, date, month, year and a century flag, all in packed BCD with a 24-hour clock. The counters advance on a one-cycle 1 Hz tick pulse.

Software never sees the live counters directly. It reads and writes holding registers, which are refreshed from the counters, all fields in one cycle, right after each counter advance. A control byte has two bits. The freeze bit stops the refresh, so software can read a coherent time. The set bit also stops the refresh, so software can load a new time into the holding registers. Clearing the set bit copies the holding registers into the counters in a single cycle. The seconds byte carries a stop bit that gates the tick. The day byte carries a century-enable bit, which allows the century flag to toggle when the year rolls from 99 to 00.

Top module: `rtc_bcd_window`

## Requirements
- R1: The window covers addresses 1FF8h-1FFFh, with offset 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. Each accepted tick advances the time by one second in packed BCD, carrying seconds 59->00, minutes 59->00, hours 23->00 and day of week 7->1.
- R2: While control bit 6 (freeze) is 1, the holding registers keep their values through any number of ticks. After the bit returns to 0, the next tick refreshes them with the live count, including the seconds counted while frozen.
- R3: While control bit 7 (set) is 1, refresh is suppressed. A control write that changes bit 7 from 1 to 0 loads all holding time fields into the counters in that cycle. A tick that arrives in the same cycle is dropped.
- R4: A refresh copies every field in one cycle, on the cycle after the counter advances. A freeze write that lands in that same refresh cycle does not cancel the refresh: the frozen values are the ones just refreshed.
- R5: Seconds bit 7 is the stop bit. It resets to 1, it is written directly by any write to offset 1, and while it is 1 ticks are ignored. The osc_stop output mirrors it.
- R6: The date rolls over to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February, or day 29 when the year value is divisible by 4 (year 00 included). Month rolls over from 12 to 01 and increments the year, and year rolls over from 99 to 00.
- R7: Day byte bit 5 is century enable and is written directly by any day write. Bit 4 is the century flag. The flag toggles at the year 99->00 rollover only when century enable is 1.
- R8: Bits without a field read 0. The read masks are control C0h, minutes 7Fh, hours 3Fh, day 37h (bit 2..0 day of week), date 3Fh and month 1Fh. After reset the bytes read: control 00h, seconds 80h, minutes, hours and year 00h, day 01h, date 01h, month 01h.
- R9: Addresses below 1FF8h assert ram_sel and return ram_rdata on bus_rdata. Writes to them leave the clock untouched.
- R10: A write to a time field while neither control bit is set is accepted into the holding register and can be read back. It is replaced by the live value at the next refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational by default) |
| ram_rdata | input | 8 | Read data from the external RAM |
| ram_sel | output | 1 | Access targets the external RAM |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| osc_stop | output | 1 | Stop request to the oscillator |

## Verification
Two pairs of events can fall in the same clock edge. In the first, a refresh coincides with a write that sets freeze; in the second, a tick coincides with the control write that clears the set bit. The bench lines up each pair exactly: it drives the control write on the edge after the tick, or on the same edge as the tick. It then judges the outcome from the seconds value that later reads return: the refreshed value must remain frozen, and the dropped tick must be missing from the count. Calendar rollover is swept over every month of every year 00-99, from both the second-to-last and the last day of the month.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // register offsets inside the eight-byte window
   localparam logic [2:0] OFF_CTRL = 3'd0;
   localparam logic [2:0] OFF_SEC  = 3'd1;
   localparam logic [2:0] OFF_MIN  = 3'd2;
   localparam logic [2:0] OFF_HR   = 3'd3;
   localparam logic [2:0] OFF_DAY  = 3'd4;
   localparam logic [2:0] OFF_DATE = 3'd5;
   localparam logic [2:0] OFF_MON  = 3'd6;
   localparam logic [2:0] OFF_YR   = 3'd7;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hr;
      logic [2:0] dow;
      logic       cb;
      logic [5:0] date;
      logic [4:0] mon;
      logic [7:0] yr;
   } rtc_time_t;

   localparam rtc_time_t RTC_TIME_RST = '{sec: 7'h00, min: 7'h00, hr: 6'h00,
                                          dow: 3'd1, cb: 1'b0, date: 6'h01,
                                          mon: 5'h01, yr: 8'h00};

   function automatic logic [6:0] bcd2bin(input logic [7:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] month_days(input logic [6:0] mon_bin, input logic leap);
      case (mon_bin)
         7'd2:                         return leap ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:      return 7'd30;
         default:                      return 7'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic setmode_d_i,
   input  logic freeze_d_i,
   output logic setmode_o,
   output logic freeze_o,
   output logic frozen_o,
   output logic commit_o
);
   logic setmode_q, freeze_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setmode_q <= 1'b0;
         freeze_q  <= 1'b0;
      end else if (wr_i) begin
         setmode_q <= setmode_d_i;
         freeze_q  <= freeze_d_i;
      end
   end

   // falling edge of the set bit caused by a bus write
   assign commit_o  = wr_i & setmode_q & ~setmode_d_i;
   assign setmode_o = setmode_q;
   assign freeze_o  = freeze_q;
   assign frozen_o  = setmode_q | freeze_q;

   // R3: commit only ever follows a cycle in set mode
   p_commit_from_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !setmode_q);

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
   import rtc_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick_i,
   input  logic      load_i,
   input  rtc_time_t load_val_i,
   input  logic      stop_wr_i,
   input  logic      stop_d_i,
   input  logic      cent_wr_i,
   input  logic      cent_d_i,
   output rtc_time_t cnt_o,
   output logic      stop_o,
   output logic      cent_en_o,
   output logic      adv_o
);
   rtc_time_t cnt_q, nxt;
   logic      stop_q, cent_en_q, adv_q;
   logic      leap;
   logic [6:0] sec_b, min_b, hr_b, date_b, mon_b, yr_b, last_b;
   logic [7:0] inc_sec, inc_min, inc_hr, inc_date, inc_mon, inc_yr;
   logic       advance;

   assign sec_b  = bcd2bin({1'b0, cnt_q.sec});
   assign min_b  = bcd2bin({1'b0, cnt_q.min});
   assign hr_b   = bcd2bin({2'b0, cnt_q.hr});
   assign date_b = bcd2bin({2'b0, cnt_q.date});
   assign mon_b  = bcd2bin({3'b0, cnt_q.mon});
   assign yr_b   = bcd2bin(cnt_q.yr);

   assign inc_sec  = bcd_inc({1'b0, cnt_q.sec});
   assign inc_min  = bcd_inc({1'b0, cnt_q.min});
   assign inc_hr   = bcd_inc({2'b0, cnt_q.hr});
   assign inc_date = bcd_inc({2'b0, cnt_q.date});
   assign inc_mon  = bcd_inc({3'b0, cnt_q.mon});
   assign inc_yr   = bcd_inc(cnt_q.yr);

   generate
      if (LEAP_EN) begin : g_leap4
         assign leap = (yr_b[1:0] == 2'b00);
      end else begin : g_noleap
         assign leap = 1'b0;
      end
   endgenerate

   assign last_b = month_days(mon_b, leap);

   always_comb begin
      nxt = cnt_q;
      if (sec_b >= 7'd59) begin
         nxt.sec = 7'h00;
         if (min_b >= 7'd59) begin
            nxt.min = 7'h00;
            if (hr_b >= 7'd23) begin
               nxt.hr  = 6'h00;
               nxt.dow = (cnt_q.dow >= 3'd7 || cnt_q.dow == 3'd0) ? 3'd1 : cnt_q.dow + 3'd1;
               if (date_b >= last_b) begin
                  nxt.date = 6'h01;
                  if (mon_b >= 7'd12) begin
                     nxt.mon = 5'h01;
                     if (yr_b >= 7'd99) begin
                        nxt.yr = 8'h00;
                        if (cent_en_q) nxt.cb = ~cnt_q.cb;
                     end else begin
                        nxt.yr = inc_yr;
                     end
                  end else begin
                     nxt.mon = inc_mon[4:0];
                  end
               end else begin
                  nxt.date = inc_date[5:0];
               end
            end else begin
               nxt.hr = inc_hr[5:0];
            end
         end else begin
            nxt.min = inc_min[6:0];
         end
      end else begin
         nxt.sec = inc_sec[6:0];
      end
   end

   // a commit load takes priority over a tick in the same cycle
   assign advance = tick_i & ~stop_q & ~load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= RTC_TIME_RST;
         stop_q    <= 1'b1;
         cent_en_q <= 1'b0;
         adv_q     <= 1'b0;
      end else begin
         if (load_i)       cnt_q <= load_val_i;
         else if (advance) cnt_q <= nxt;
         if (stop_wr_i) stop_q    <= stop_d_i;
         if (cent_wr_i) cent_en_q <= cent_d_i;
         adv_q <= advance;
      end
   end

   assign cnt_o     = cnt_q;
   assign stop_o    = stop_q;
   assign cent_en_o = cent_en_q;
   assign adv_o     = adv_q;

   // R5: stopped counters do not move unless loaded
   p_stop_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !load_i) |=> $stable(cnt_q));
   // R3: a commit puts the loaded value in the counters, tick or not
   p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));
   // R7: century flag is fixed while century enable is clear
   p_cent_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cent_en_q && !load_i) |=> $stable(cnt_q.cb));
   // R1: no advance pulse without a tick one cycle earlier
   p_adv_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> !adv_q);

endmodule

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frozen_i,
   input  logic       refresh_i,
   input  rtc_time_t  cnt_i,
   input  logic       wr_i,
   input  logic [2:0] off_i,
   input  logic [7:0] wdata_i,
   output rtc_time_t  hold_o
);
   rtc_time_t hold_q;
   logic      do_refresh, field_wr;

   assign do_refresh = refresh_i & ~frozen_i;
   assign field_wr   = wr_i & (off_i != OFF_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= RTC_TIME_RST;
      end else if (do_refresh) begin
         hold_q <= cnt_i;
      end else if (field_wr) begin
         case (off_i)
            OFF_SEC:  hold_q.sec  <= wdata_i[6:0];
            OFF_MIN:  hold_q.min  <= wdata_i[6:0];
            OFF_HR:   hold_q.hr   <= wdata_i[5:0];
            OFF_DAY: begin
               hold_q.dow <= wdata_i[2:0];
               hold_q.cb  <= wdata_i[4];
            end
            OFF_DATE: hold_q.date <= wdata_i[5:0];
            OFF_MON:  hold_q.mon  <= wdata_i[4:0];
            OFF_YR:   hold_q.yr   <= wdata_i;
            default:  hold_q      <= hold_q;
         endcase
      end
   end

   assign hold_o = hold_q;

   // R2: frozen holding registers change only by bus writes
   p_freeze_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_i && !field_wr) |=> $stable(hold_q));
   // R4: a refresh copies every field together
   p_refresh_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_i && !frozen_i) |=> (hold_q == $past(cnt_i)));

endmodule

// File: rtl/rtc_bcd_window.sv
module rtc_bcd_window
   import rtc_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter bit LEAP_EN   = 1'b1,
   parameter bit RDATA_REG = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_sel,
   input  logic              tick_1hz,
   output logic              osc_stop
);
   localparam int TAG_W = ADDR_W - 3;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("rtc_bcd_window: DATA_W must be 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("rtc_bcd_window: ADDR_W must be at least 4");
      end
   endgenerate

   logic        win_hit, wr_win, ctrl_wr;
   logic [2:0]  off;
   logic        setmode, freeze, frozen, commit;
   logic        stop, cent_en, adv;
   rtc_time_t   cnt, hold;
   logic [7:0]  win_rdata;
   logic [DATA_W-1:0] rdata_c;

   assign win_hit = (bus_addr[ADDR_W-1:3] == {TAG_W{1'b1}});
   assign off     = bus_addr[2:0];
   assign wr_win  = bus_sel & bus_we & win_hit;
   assign ctrl_wr = wr_win & (off == OFF_CTRL);
   assign ram_sel = bus_sel & ~win_hit;

   rtc_ctrl_reg u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (ctrl_wr),
      .setmode_d_i (bus_wdata[7]),
      .freeze_d_i  (bus_wdata[6]),
      .setmode_o   (setmode),
      .freeze_o    (freeze),
      .frozen_o    (frozen),
      .commit_o    (commit)
   );

   rtc_time_counter #(.LEAP_EN(LEAP_EN)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_1hz),
      .load_i     (commit),
      .load_val_i (hold),
      .stop_wr_i  (wr_win & (off == OFF_SEC)),
      .stop_d_i   (bus_wdata[7]),
      .cent_wr_i  (wr_win & (off == OFF_DAY)),
      .cent_d_i   (bus_wdata[5]),
      .cnt_o      (cnt),
      .stop_o     (stop),
      .cent_en_o  (cent_en),
      .adv_o      (adv)
   );

   rtc_hold_regs u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .frozen_i  (frozen),
      .refresh_i (adv),
      .cnt_i     (cnt),
      .wr_i      (wr_win),
      .off_i     (off),
      .wdata_i   (bus_wdata),
      .hold_o    (hold)
   );

   always_comb begin
      case (off)
         OFF_CTRL: win_rdata = {setmode, freeze, 6'b0};
         OFF_SEC:  win_rdata = {stop, hold.sec};
         OFF_MIN:  win_rdata = {1'b0, hold.min};
         OFF_HR:   win_rdata = {2'b0, hold.hr};
         OFF_DAY:  win_rdata = {2'b0, cent_en, hold.cb, 1'b0, hold.dow};
         OFF_DATE: win_rdata = {2'b0, hold.date};
         OFF_MON:  win_rdata = {3'b0, hold.mon};
         default:  win_rdata = hold.yr;
      endcase
   end

   assign rdata_c  = win_hit ? win_rdata : ram_rdata;
   assign osc_stop = stop;

   generate
      if (RDATA_REG) begin : g_rdata_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rdata_c;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rdata_comb
         assign bus_rdata = rdata_c;
         // R9: below the window the RAM data passes straight through
         p_ram_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !win_hit |-> (bus_rdata == ram_rdata));
      end
   endgenerate

   // R9: RAM and clock are never selected together
   p_ram_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && win_hit) |-> !ram_sel);

endmodule

// File: tb/rtc_bcd_window_bench.sv
module rtc_bcd_window_bench;
   localparam time HALF = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, tick = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0, ram_rdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        ram_sel, osc_stop;

   int errors = 0, checks = 0;
   int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cb, m_cen, m_stop;

   always #HALF clk = ~clk;

   rtc_bcd_window u_rtc_bcd_window (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ram_rdata(ram_rdata), .ram_sel(ram_sel), .tick_1hz(tick), .osc_stop(osc_stop)
   );

   function automatic logic [7:0] tobcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int lastday(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic m_adv();
      if (m_sec < 59) begin m_sec++; return; end
      m_sec = 0;
      if (m_min < 59) begin m_min++; return; end
      m_min = 0;
      if (m_hr < 23) begin m_hr++; return; end
      m_hr = 0;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      if (m_date < lastday(m_mon, m_yr)) begin m_date++; return; end
      m_date = 1;
      if (m_mon < 12) begin m_mon++; return; end
      m_mon = 1;
      if (m_yr < 99) begin m_yr++; return; end
      m_yr = 0;
      if (m_cen != 0) m_cb = 1 - m_cb;
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // tick edge advances counters, next edge refreshes holding registers
   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [7:0] day_byte();
      return 8'((m_cen << 5) | (m_cb << 4) | m_dow);
   endfunction

   task automatic set_time(input int s, input int mi, input int h, input int dw,
                           input int dt, input int mo, input int y, input int cb);
      m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y;
      m_cb = cb; m_stop = 0;
      wr(13'h1FF8, 8'h80);
      wr(13'h1FF9, tobcd(s));
      wr(13'h1FFA, tobcd(mi));
      wr(13'h1FFB, tobcd(h));
      wr(13'h1FFC, day_byte());
      wr(13'h1FFD, tobcd(dt));
      wr(13'h1FFE, tobcd(mo));
      wr(13'h1FFF, tobcd(y));
      wr(13'h1FF8, 8'h00);
   endtask

   initial begin
      #(2 * HALF * 200000);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v, snap;
      m_cen = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state, R5 stop set after reset
      rd(13'h1FF8, v); chk("R8 reset ctrl", v, 8'h00);
      rd(13'h1FF9, v); chk("R5 reset seconds with stop", v, 8'h80);
      rd(13'h1FFA, v); chk("R8 reset minutes", v, 8'h00);
      rd(13'h1FFC, v); chk("R8 reset day", v, 8'h01);
      rd(13'h1FFD, v); chk("R8 reset date", v, 8'h01);
      rd(13'h1FFE, v); chk("R8 reset month", v, 8'h01);
      chk("R5 osc_stop after reset", {7'b0, osc_stop}, 8'h01);

      // R5 ticks ignored while stopped
      do_tick(); do_tick();
      rd(13'h1FF9, v); chk("R5 stopped seconds", v, 8'h80);
      wr(13'h1FF9, 8'h00);
      chk("R5 osc_stop cleared", {7'b0, osc_stop}, 8'h00);
      do_tick();
      rd(13'h1FF9, v); chk("R5 R1 first second", v, 8'h01);

      // R1 carries through hour and day of week
      m_cen = 0;
      set_time(58, 59, 23, 7, 10, 5, 23, 0);
      do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R1 seconds 59", v, tobcd(m_sec));
      do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R1 seconds wrap", v, 8'h00);
      rd(13'h1FFA, v); chk("R1 minutes wrap", v, 8'h00);
      rd(13'h1FFB, v); chk("R1 hours wrap", v, 8'h00);
      rd(13'h1FFC, v); chk("R1 day of week 7 to 1", v, 8'h01);
      rd(13'h1FFD, v); chk("R1 date step", v, 8'h11);

      // R3 commit value visible and counted
      set_time(30, 15, 9, 3, 4, 6, 45, 0);
      rd(13'h1FFA, v); chk("R3 committed minutes", v, 8'h15);
      do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R3 counting from commit", v, tobcd(m_sec));

      // R3 tick in the commit cycle is dropped
      wr(13'h1FF8, 8'h80);
      wr(13'h1FF9, 8'h10);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 13'h1FF8; bus_wdata = 8'h00; tick = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
      m_sec = 10;
      do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R3 tick dropped at commit", v, 8'h11);

      // R2 freeze keeps values, then catches up
      wr(13'h1FF8, 8'h40);
      snap = tobcd(m_sec);
      do_tick(); m_adv(); do_tick(); m_adv(); do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R2 frozen seconds", v, snap);
      rd(13'h1FF8, v); chk("R2 freeze bit reads", v, 8'h40);
      wr(13'h1FF8, 8'h00);
      do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R2 catch up after freeze", v, tobcd(m_sec));

      // R4 freeze written in the refresh cycle: refresh still lands
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 13'h1FF8; bus_wdata = 8'h40;
      @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
      m_adv(); snap = tobcd(m_sec);
      do_tick(); m_adv(); do_tick(); m_adv();
      rd(13'h1FF9, v); chk("R4 refresh wins over freeze", v, snap);
      wr(13'h1FF8, 8'h00);

      // R10 unfrozen write accepted then replaced
      wr(13'h1FFA, 8'h45);
      rd(13'h1FFA, v); chk("R10 write accepted", v, 8'h45);
      do_tick(); m_adv();
      rd(13'h1FFA, v); chk("R10 replaced at refresh", v, tobcd(m_min));

      // R8 zero bits
      wr(13'h1FF8, 8'hFF);
      rd(13'h1FF8, v); chk("R8 ctrl mask", v, 8'hC0);
      wr(13'h1FFB, 8'hFF); rd(13'h1FFB, v); chk("R8 hours mask", v, 8'h3F);
      wr(13'h1FFE, 8'hFF); rd(13'h1FFE, v); chk("R8 month mask", v, 8'h1F);
      wr(13'h1FFD, 8'hFF); rd(13'h1FFD, v); chk("R8 date mask", v, 8'h3F);
      wr(13'h1FFA, 8'hFF); rd(13'h1FFA, v); chk("R8 minutes mask", v, 8'h7F);
      wr(13'h1FFC, 8'hFF); rd(13'h1FFC, v); chk("R8 R7 day mask", v, 8'h37);
      m_cen = 0;
      set_time(0, 0, 12, 2, 2, 2, 2, 0);

      // R9 RAM pass-through and window exclusion
      ram_rdata = 8'hA5;
      @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 13'h0123;
      #1 chk("R9 ram data passes", bus_rdata, 8'hA5);
      chk("R9 ram_sel low address", {7'b0, ram_sel}, 8'h01);
      bus_addr = 13'h1FF8;
      #1 chk("R9 ram_sel in window", {7'b0, ram_sel}, 8'h00);
      bus_sel = 1'b0;
      rd(13'h1FF7, v); chk("R9 below window reads ram", v, 8'hA5);
      wr(13'h1FF7, 8'hC0);
      rd(13'h1FF8, v); chk("R9 write below window ignored", v, 8'h00);
      ram_rdata = 8'h00;

      // R7 century toggles only when enabled
      m_cen = 1;
      set_time(59, 59, 23, 3, 31, 12, 99, 0);
      do_tick(); m_adv();
      rd(13'h1FFC, v); chk("R7 century toggled", v, 8'h34);
      rd(13'h1FFF, v); chk("R7 R6 year wrap", v, 8'h00);
      m_cen = 0;
      set_time(59, 59, 23, 3, 31, 12, 99, 1);
      do_tick(); m_adv();
      rd(13'h1FFC, v); chk("R7 century held", v, 8'h14);

      // R6 sweep every month of every year
      m_cen = 0;
      for (int y = 0; y < 100; y++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_time(59, 59, 23, 5, lastday(mo, y) - 1, mo, y, 0);
            do_tick(); m_adv();
            rd(13'h1FFD, v); chk("R6 last day reached", v, tobcd(m_date));
            set_time(59, 59, 23, 5, lastday(mo, y), mo, y, 0);
            do_tick(); m_adv();
            rd(13'h1FFD, v); chk("R6 date wraps", v, 8'h01);
            rd(13'h1FFE, v); chk("R6 month after wrap", v, tobcd(m_mon));
            rd(13'h1FFF, v); chk("R6 year after wrap", v, tobcd(m_yr));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule